// File: doc/BRIEF.md
# Quasi-Bidirectional Port Register

This block holds the output latch of an 8-bit general-purpose port in a small microcontroller core and turns each latch bit into pad controls. No direction register exists. A latch bit of 0 turns the pin's pull-down on. A latch bit of 1 turns the pull-down off and leaves a weak pull-up on, so an outside device can still pull the pin low. That pin then works as an input. Whenever a latch bit goes from 0 to 1, a strong pull-up on that pin is switched on for a short fixed time so the line rises quickly.

The core reaches the port over a simple register bus. The latch is mapped at one byte address and also at eight bit addresses, one for each bit. The bus supports whole-byte writes, AND/OR/XOR mask updates, and single-bit set, clear and complement. Every modifying operation takes its operand from the latch and never from the pins. This stops an input pin that happens to read low from being written back as a stuck 0.

Byte reads and bit reads return the pin levels after a two-flop synchronizer. A separate read kind returns the latch itself. Read data is registered and appears one cycle after the request.

Top module: `qport_top`

## Requirements
- R1: After reset the latch is 0xFF: `weakUp` is 0xFF, `pullDown` is 0x00, `strongUp` is 0x00 and `rdValid` is 0.
- R2: Opcode 3 (byte write) at byte address 0x90 loads `wrData` into the latch. At all times `weakUp` equals the latch and `pullDown` equals its inverse.
- R3: Opcodes 4 (AND), 5 (OR) and 6 (XOR) at byte address 0x90 combine `wrData` with the latch. The pin levels have no effect on the result.
- R4: Opcodes 7 (set), 8 (clear) and 9 (complement) act on the single bit at `bitAddr` minus 0x90 (0x90 is bit 0, 0x97 is bit 7). All other bits keep their value, and the operand is the latch.
- R5: Opcode 0 (pin byte read) at byte address 0x90 returns the pin levels as they stand after two synchronizer flops. A pin change becomes visible to a read issued two clock edges after the change.
- R6: Opcode 1 (pin bit read) returns the synchronized level of the pin selected by `bitAddr` in `rdData[0]`, with bits 7:1 at zero.
- R7: Opcode 2 (latch read) at byte address 0x90 returns the latch contents.
- R8: When a latch bit goes from 0 to 1, its `strongUp` bit is high for exactly 2 cycles, starting in the cycle after the write edge. A write that leaves a 1 unchanged does not start a pulse.
- R9: A latch bit that returns to 0 while its pulse is running ends the pulse in the same cycle.
- R10: For any bit, `weakUp` and `pullDown` are never both high, and `strongUp` is high only while `weakUp` is high.
- R11: A bit operation with `bitAddr` outside 0x90..0x97, or a byte operation with `byteAddr` other than 0x90, leaves the latch unchanged. Such reads return 0x00.
- R12: `rdValid` is high for exactly the one cycle after each accepted read request (opcodes 0, 1, 2), whether or not the address hits, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Bus request strobe, one cycle per operation |
| opCode | input | 4 | Operation code (0..9, other values do nothing) |
| byteAddr | input | 8 | Byte address for byte operations |
| bitAddr | input | 8 | Bit address for single-bit operations |
| wrData | input | 8 | Write data or mask |
| pinIn | input | 8 | Asynchronous pin levels from the pads |
| rdValid | output | 1 | Read data valid |
| rdData | output | 8 | Read data, held between reads |
| pullDown | output | 8 | Per-pin pull-down enable |
| weakUp | output | 8 | Per-pin weak pull-up enable |
| strongUp | output | 8 | Per-pin momentary strong pull-up enable |

## Verification
The cycle-by-cycle assertions cover the relations between the pad controls: the pull-down and weak pull-up are exclusive, the strong pull-up only runs under the weak one, and a strong pulse starts exactly when a weak pull-up rises. They also check that a pulse never runs longer than its set length and always runs its full length unless the bit falls. They watch the read strobe timing and the zero data returned for missed addresses as well. Only the bench's scenarios can show that the latch arithmetic comes out right for each operation, that mask operations ignore pins held low, that bit addresses select the correct bit, and the exact delay of a pin change through the synchronizer.

// File: rtl/qport_pkg.sv
package qport_pkg;

  typedef enum logic [3:0] {
    OP_RD_PINS  = 4'd0,
    OP_RD_BIT   = 4'd1,
    OP_RD_LATCH = 4'd2,
    OP_WR_BYTE  = 4'd3,
    OP_AND      = 4'd4,
    OP_OR       = 4'd5,
    OP_XOR      = 4'd6,
    OP_SET      = 4'd7,
    OP_CLR      = 4'd8,
    OP_CPL      = 4'd9
  } op_e;

  // strobes from control to datapath; address hits already folded in
  typedef struct packed {
    logic ldByte;
    logic andMask;
    logic orMask;
    logic xorMask;
    logic setBit;
    logic clrBit;
    logic cplBit;
    logic rdPins;
    logic rdPinBit;
    logic rdLatch;
    logic rdAny;
  } ctrl_t;

endpackage

// File: rtl/qport_ctrl.sv
module qport_ctrl
  import qport_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BYTE_ADDR = 8'h90,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h90,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic              reqValid,
  input  logic [3:0]        opCode,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [ADDR_W-1:0] bitAddr,
  output ctrl_t             st,
  output logic [IDXW-1:0]   bitIdx
);

  logic [ADDR_W:0] bitOff;
  logic byteHit;
  logic bitHit;

  always_comb begin
    bitOff  = {1'b0, bitAddr} - {1'b0, BIT_BASE};
    byteHit = (byteAddr == BYTE_ADDR);
    bitHit  = (bitOff < (ADDR_W + 1)'(WIDTH));
    bitIdx  = IDXW'(bitOff);
  end

  always_comb begin
    st = '0;
    if (reqValid) begin
      case (op_e'(opCode))
        OP_RD_PINS:  begin st.rdPins   = byteHit; st.rdAny = 1'b1; end
        OP_RD_BIT:   begin st.rdPinBit = bitHit;  st.rdAny = 1'b1; end
        OP_RD_LATCH: begin st.rdLatch  = byteHit; st.rdAny = 1'b1; end
        OP_WR_BYTE:  st.ldByte  = byteHit;
        OP_AND:      st.andMask = byteHit;
        OP_OR:       st.orMask  = byteHit;
        OP_XOR:      st.xorMask = byteHit;
        OP_SET:      st.setBit  = bitHit;
        OP_CLR:      st.clrBit  = bitHit;
        OP_CPL:      st.cplBit  = bitHit;
        default:     st = '0;
      endcase
    end
  end

endmodule

// File: rtl/qport_dp.sv
module qport_dp
  import qport_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN = 2,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            st,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic             rdValid,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pullDown,
  output logic [WIDTH-1:0] weakUp,
  output logic [WIDTH-1:0] strongUp
);

  logic [WIDTH-1:0] portLatch;
  logic [WIDTH-1:0] latchNext;
  logic [WIDTH-1:0] bitMask;
  logic [WIDTH-1:0] pinSync;
  logic [WIDTH-1:0] rdNext;

  // pin synchronizer chain, idles high like the pads
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '1;
    else       syncQ[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '1;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign pinSync = syncQ[SYNC_STAGES-1];

  // latch update: every operand comes from the latch, never the pins
  always_comb begin
    bitMask = WIDTH'(1) << bitIdx;
    latchNext = portLatch;
    if (st.ldByte)       latchNext = wrData;
    else if (st.andMask) latchNext = portLatch & wrData;
    else if (st.orMask)  latchNext = portLatch | wrData;
    else if (st.xorMask) latchNext = portLatch ^ wrData;
    else if (st.setBit)  latchNext = portLatch | bitMask;
    else if (st.clrBit)  latchNext = portLatch & ~bitMask;
    else if (st.cplBit)  latchNext = portLatch ^ bitMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) portLatch <= '1;
    else       portLatch <= latchNext;
  end

  // per-bit strong pull-up pulse timers
  for (genvar b = 0; b < WIDTH; b++) begin : g_pulse
    logic [CNT_W-1:0] pulseCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pulseCnt <= '0;
      end else if (!latchNext[b]) begin
        pulseCnt <= '0;
      end else if (!portLatch[b]) begin
        pulseCnt <= CNT_W'(PULSE_LEN);
      end else if (pulseCnt != '0) begin
        pulseCnt <= pulseCnt - 1'b1;
      end
    end

    assign strongUp[b] = (pulseCnt != '0);
  end

  assign weakUp   = portLatch;
  assign pullDown = ~portLatch;

  // read path, one cycle latency; misses read as zero
  always_comb begin
    rdNext = '0;
    if (st.rdPins)        rdNext = pinSync;
    else if (st.rdPinBit) rdNext = WIDTH'(pinSync[bitIdx]);
    else if (st.rdLatch)  rdNext = portLatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= st.rdAny;
      if (st.rdAny) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/qport_top.sv
module qport_top
  import qport_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BYTE_ADDR = 8'h90,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h90,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN = 2,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        opCode,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [ADDR_W-1:0] bitAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [WIDTH-1:0]  pinIn,
  output logic              rdValid,
  output logic [WIDTH-1:0]  rdData,
  output logic [WIDTH-1:0]  pullDown,
  output logic [WIDTH-1:0]  weakUp,
  output logic [WIDTH-1:0]  strongUp
);

  ctrl_t st;
  logic [IDXW-1:0] bitIdx;

  qport_ctrl #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .BYTE_ADDR(BYTE_ADDR), .BIT_BASE(BIT_BASE)
  ) u_ctrl (
    .reqValid(reqValid), .opCode(opCode), .byteAddr(byteAddr),
    .bitAddr(bitAddr), .st(st), .bitIdx(bitIdx)
  );

  qport_dp #(
    .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .PULSE_LEN(PULSE_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .bitIdx(bitIdx), .wrData(wrData),
    .pinIn(pinIn), .rdValid(rdValid), .rdData(rdData),
    .pullDown(pullDown), .weakUp(weakUp), .strongUp(strongUp)
  );

endmodule

// File: rtl/qport_chk.sv
module qport_chk #(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BYTE_ADDR = 8'h90,
  parameter int PULSE_LEN = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [3:0]        opCode,
  input logic [ADDR_W-1:0] byteAddr,
  input logic              rdValid,
  input logic [WIDTH-1:0]  rdData,
  input logic [WIDTH-1:0]  pullDown,
  input logic [WIDTH-1:0]  weakUp,
  input logic [WIDTH-1:0]  strongUp
);

  logic isRead;
  assign isRead = reqValid && (opCode <= 4'd2);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (weakUp & pullDown) == '0);

  a_r10_strong_under_weak: assert property (@(posedge clk) disable iff (!rstN)
    (strongUp & ~weakUp) == '0);

  a_r8_pulse_starts_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    (strongUp & ~$past(strongUp)) == (weakUp & ~$past(weakUp)));

  a_r12_valid_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid == $past(isRead));

  a_r11_miss_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid && (opCode == 4'd0 || opCode == 4'd2) && byteAddr != BYTE_ADDR)
    |-> rdData == '0);

  for (genvar b = 0; b < WIDTH; b++) begin : g_len
    logic [7:0] runLen;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            runLen <= '0;
      else if (strongUp[b]) runLen <= runLen + 1'b1;
      else                  runLen <= '0;
    end

    a_r8_len_cap: assert property (@(posedge clk) disable iff (!rstN)
      strongUp[b] |-> runLen < 8'(PULSE_LEN));

    // R9 allows early end only when the bit falls
    a_r9_full_unless_fall: assert property (@(posedge clk) disable iff (!rstN)
      (!strongUp[b] && $past(strongUp[b]) && weakUp[b]) |-> runLen == 8'(PULSE_LEN));
  end

endmodule

bind qport_top qport_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .BYTE_ADDR(BYTE_ADDR), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .opCode(opCode),
  .byteAddr(byteAddr), .rdValid(rdValid), .rdData(rdData),
  .pullDown(pullDown), .weakUp(weakUp), .strongUp(strongUp)
);

// File: tb/qport_top_tb.sv
`timescale 1ns/1ps
module qport_top_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] byteAddr = '0;
  logic [7:0] bitAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] pinIn = 8'hFF;
  logic rdValid;
  logic [7:0] rdData, pullDown, weakUp, strongUp;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  qport_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opCode(opCode),
    .byteAddr(byteAddr), .bitAddr(bitAddr), .wrData(wrData), .pinIn(pinIn),
    .rdValid(rdValid), .rdData(rdData), .pullDown(pullDown),
    .weakUp(weakUp), .strongUp(strongUp)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // called just after a falling edge; request sampled on the next rising edge
  task automatic doReq(logic [3:0] op, logic [7:0] ba, logic [7:0] bta, logic [7:0] d);
    reqValid = 1'b1; opCode = op; byteAddr = ba; bitAddr = bta; wrData = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // R10 on every sampled cycle
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R10", "weak&pulldown", weakUp & pullDown, 8'h00);
      check("R10", "strong&~weak", strongUp & ~weakUp, 8'h00);
    end
  end

  // {op, byteAddr, bitAddr, wrData, pins, expected latch}
  localparam logic [43:0] VEC [13] = '{
    {4'd3, 8'h90, 8'h00, 8'h00, 8'h00, 8'h00},  // R2 byte write
    {4'd3, 8'h90, 8'h00, 8'hA5, 8'h00, 8'hA5},  // R2
    {4'd5, 8'h90, 8'h00, 8'h0F, 8'h00, 8'hAF},  // R3 OR
    {4'd4, 8'h90, 8'h00, 8'h3C, 8'h00, 8'h2C},  // R3 AND
    {4'd6, 8'h90, 8'h00, 8'hFF, 8'h00, 8'hD3},  // R3 XOR
    {4'd7, 8'h00, 8'h92, 8'h00, 8'h00, 8'hD7},  // R4 set bit 2
    {4'd8, 8'h00, 8'h97, 8'h00, 8'h00, 8'h57},  // R4 clear bit 7
    {4'd9, 8'h00, 8'h90, 8'h00, 8'h00, 8'h56},  // R4 complement bit 0
    {4'd7, 8'h00, 8'h98, 8'h00, 8'h00, 8'h56},  // R11 bit address above range
    {4'd3, 8'h91, 8'h00, 8'h00, 8'h00, 8'h56},  // R11 wrong byte address
    {4'd4, 8'h91, 8'h00, 8'h00, 8'h00, 8'h56},  // R11
    {4'd8, 8'h00, 8'h8F, 8'h00, 8'h00, 8'h56},  // R11 bit address below range
    {4'd4, 8'h90, 8'h00, 8'hFF, 8'h00, 8'h56}   // R3 pins low, latch kept
  };

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "weakUp", weakUp, 8'hFF);
    check("R1", "pullDown", pullDown, 8'h00);
    check("R1", "strongUp", strongUp, 8'h00);
    check("R1", "rdValid", {7'd0, rdValid}, 8'h00);
    rstN = 1'b1;
    pinIn = 8'h00;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 13; i++) begin
      pinIn = VEC[i][15:8];
      doReq(VEC[i][43:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16]);
      check("R2/R3/R4/R11", $sformatf("row %0d weakUp", i), weakUp, VEC[i][7:0]);
      check("R2", $sformatf("row %0d pullDown", i), pullDown, ~VEC[i][7:0]);
    end

    // R7 latch read
    doReq(4'd2, 8'h90, 8'h00, 8'h00);
    check("R7", "latch read", rdData, 8'h56);
    check("R12", "valid after read", {7'd0, rdValid}, 8'h01);
    @(negedge clk);
    check("R12", "valid drops", {7'd0, rdValid}, 8'h00);

    // R5 pin read
    pinIn = 8'h3C;
    repeat (3) @(negedge clk);
    doReq(4'd0, 8'h90, 8'h00, 8'h00);
    check("R5", "pin read", rdData, 8'h3C);
    // R5 synchronizer depth: change seen only two edges later
    pinIn = 8'hC3;
    @(negedge clk);
    doReq(4'd0, 8'h90, 8'h00, 8'h00);
    check("R5", "old pins after one edge", rdData, 8'h3C);
    doReq(4'd0, 8'h90, 8'h00, 8'h00);
    check("R5", "new pins after two edges", rdData, 8'hC3);

    // R6 pin bit reads
    doReq(4'd1, 8'h00, 8'h97, 8'h00);
    check("R6", "bit 7", rdData, 8'h01);
    doReq(4'd1, 8'h00, 8'h92, 8'h00);
    check("R6", "bit 2", rdData, 8'h00);
    doReq(4'd1, 8'h00, 8'h90, 8'h00);
    check("R6", "bit 0", rdData, 8'h01);

    // R11 missed reads
    doReq(4'd1, 8'h00, 8'h98, 8'h00);
    check("R11", "bit read miss", rdData, 8'h00);
    check("R12", "valid on miss", {7'd0, rdValid}, 8'h01);
    doReq(4'd0, 8'h91, 8'h00, 8'h00);
    check("R11", "pin read miss", rdData, 8'h00);
    doReq(4'd2, 8'h80, 8'h00, 8'h00);
    check("R11", "latch read miss", rdData, 8'h00);

    // R8 pulse length
    doReq(4'd3, 8'h90, 8'h00, 8'h00);
    check("R8", "no pulse on fall", strongUp, 8'h00);
    doReq(4'd3, 8'h90, 8'h00, 8'h81);
    check("R8", "pulse cycle 1", strongUp, 8'h81);
    @(negedge clk);
    check("R8", "pulse cycle 2", strongUp, 8'h81);
    @(negedge clk);
    check("R8", "pulse over", strongUp, 8'h00);
    check("R8", "weak stays", weakUp, 8'h81);
    doReq(4'd3, 8'h90, 8'h00, 8'hFF);
    check("R8", "only rising bits pulse", strongUp, 8'h7E);
    repeat (2) @(negedge clk);

    // R9 fall during pulse ends it
    doReq(4'd3, 8'h90, 8'h00, 8'h00);
    doReq(4'd3, 8'h90, 8'h00, 8'hFF);
    check("R9", "pulse all", strongUp, 8'hFF);
    doReq(4'd3, 8'h90, 8'h00, 8'h0F);
    check("R9", "high nibble cut", strongUp, 8'h0F);
    @(negedge clk);
    check("R9", "pulse over", strongUp, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule